// File: doc/BRIEF.md
# Lockable GPIO Bank with Debounced Event Routing

This block is a bank of general-purpose pins. Each pin has its own configuration word, written through a simple register port. The word selects four things:

- how the output is driven: push-pull, open-drain or off;
- whether a pull-up is requested from the pad;
- the output data bit;
- the input edge that counts as an event, and which of three event lines (interrupt, system-management interrupt, power-up request) that event feeds.

Pad inputs are brought into the clock domain by a two-flop synchronizer. A counter filter then rejects short glitches. A qualifying edge of the filtered input sets a sticky pending bit, and software clears that bit by writing 1 to it. Each event line is the OR of the pending bits whose routing enable for that line is set.

A per-pin lock bit freezes that pin's whole configuration word. Software can set the lock bit but cannot clear it; only reset clears it. The lock protects board-critical pins from later software. The pad cells themselves sit outside the block and take `pin_out`, `pin_oe` and `pin_pu` directly.

Top module: `lockgpio_bank`

## Requirements
- R1: After reset, every configuration word and every lock bit reads 0, and every pending bit reads 0. `pin_oe`, `pin_pu`, `irq_o`, `smi_o` and `wake_o` are all 0.
- R2: Bits [1:0] of a pin's configuration word select its drive type. Code 01 is push-pull and holds `pin_oe` at 1. Code 10 is open-drain and drives `pin_oe` as the inverse of the data bit. Codes 00 and 11 turn the output off, so `pin_oe` is 0. In every mode `pin_out` follows data bit 3.
- R3: Bit 2 of a pin's configuration word drives that pin's `pin_pu` output.
- R4: With the default of 8 pins, the register addresses are as follows:
  - addresses 0 to 7 hold the configuration words of pins 0 to 7, and each word reads back as written;
  - address 8 holds the lock vector;
  - address 9 holds the pending vector;
  - address 10 is a read-only copy of the filtered inputs.
  In general the lock vector sits at address NPINS, the pending vector at NPINS+1 and the inputs at NPINS+2.
- R5: Writing 1 to a bit of the lock vector sets that pin's lock. Writing 0 to a lock bit has no effect. A lock bit is cleared only by reset.
- R6: A write to the configuration word of a locked pin is ignored entirely: drive type, pull-up, data, polarity and routing all keep their values. Pins that are not locked remain writable.
- R7: The filtered input takes a new level only after the synchronized input has shown that level for DB_LEN consecutive clocks (default 16). A pulse lasting DB_LEN-1 clocks is rejected, and a pulse lasting DB_LEN clocks is accepted.
- R8: Bit 4 of a pin's configuration word selects its event edge: 1 selects a rising edge of the filtered input and 0 selects a falling edge. The selected edge sets the pin's pending bit whatever the routing bits are. The other edge does not set it.
- R9: Writing 1 to a bit of the pending vector clears that bit. Writing 0 to a pending bit leaves it unchanged.
- R10: Bits 5, 6 and 7 of a pin's configuration word enable routing of its pending bit to `irq_o`, `smi_o` and `wake_o` respectively. Each of these outputs is the OR of the pending bits that are routed to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the sample clock of the input filter |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from the address |
| pin_in | input | NPINS | Pad input levels, asynchronous |
| pin_out | output | NPINS | Output data to the pads |
| pin_oe | output | NPINS | Output enable to the pads |
| pin_pu | output | NPINS | Pull-up request to the pads |
| irq_o | output | 1 | Interrupt event line |
| smi_o | output | 1 | System-management interrupt event line |
| wake_o | output | 1 | Power-up request event line |

## Verification
The event assertions take two things for granted:

- A pending bit can rise only on the cycle after the edge detector fired.
- A clear that is not met by a new edge leaves the bit low.

Because the filtered inputs reset to 0, the bench holds every pad input low during reset and keeps it low until that pin's test. A spurious rising edge therefore cannot appear straight after reset. The bench also changes pad inputs only on the falling clock edge, and it holds every level for a whole number of clocks. The pulse lengths seen by the filter are then exact, so the boundary pulses of DB_LEN-1 and DB_LEN clocks test exactly the lengths intended.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    DRV_OFF  = 2'b00,
    DRV_PUSH = 2'b01,
    DRV_OPEN = 2'b10,
    DRV_RSVD = 2'b11
  } drive_e;

  // packed MSB first: bit7 wake, bit6 smi, bit5 irq, bit4 rising, bit3 data,
  // bit2 pull-up, bits1:0 drive type
  typedef struct packed {
    logic   wake_en;
    logic   smi_en;
    logic   irq_en;
    logic   rise_sel;
    logic   dout;
    logic   pull_en;
    drive_e drive;
  } pin_cfg_t;

  localparam int CFG_W = $bits(pin_cfg_t);

  // output enable for a drive type and data bit
  function automatic logic drive_oe(drive_e d, logic dout);
    case (d)
      DRV_PUSH: return 1'b1;
      DRV_OPEN: return ~dout;
      default:  return 1'b0;
    endcase
  endfunction

  // event detector: selected edge between previous and current filtered level
  function automatic logic edge_hit(logic rise_sel, logic prev, logic cur);
    return rise_sel ? (cur & ~prev) : (~cur & prev);
  endfunction

endpackage

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int DB_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level_o
);
  localparam int CW = (DB_LEN > 1) ? $clog2(DB_LEN) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(DB_LEN - 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] cnt_q;
  logic          lvl_q;
  logic          differs;
  logic          accept;

  assign differs = (s2_q != lvl_q);
  assign accept  = differs && (cnt_q == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      s1_q <= raw_in;
      s2_q <= s1_q;
      if (!differs) begin
        cnt_q <= '0;
      end else if (accept) begin
        cnt_q <= '0;
        lvl_q <= s2_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = lvl_q;

  // R7
  db_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(s2_q) == lvl_q && $past(cnt_q) == CNT_TOP));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NPINS-1:0] status_i,
  input  logic [NPINS-1:0] level_i,
  output pin_cfg_t         cfg_q [NPINS],
  output logic [NPINS-1:0] lock_q,
  output logic [NPINS-1:0] clr_o
);
  localparam logic [AW-1:0] LOCK_A = AW'(NPINS);
  localparam logic [AW-1:0] STAT_A = AW'(NPINS + 1);
  localparam logic [AW-1:0] LVL_A  = AW'(NPINS + 2);

  logic [NPINS-1:0] cfg_wr;

  genvar gi;
  generate
    for (gi = 0; gi < NPINS; gi++) begin : g_pin
      assign cfg_wr[gi] = we && (addr == AW'(gi)) && !lock_q[gi];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q[gi] <= '0;
        else if (cfg_wr[gi]) cfg_q[gi] <= pin_cfg_t'(wdata[CFG_W-1:0]);
      end

      // R5
      lk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q[gi] |=> lock_q[gi]);
      // R6
      lk_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q[gi] |=> $stable(cfg_q[gi]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= '0;
    else if (we && addr == LOCK_A) lock_q <= lock_q | wdata[NPINS-1:0];
  end

  assign clr_o = (we && addr == STAT_A) ? wdata[NPINS-1:0] : '0;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (addr == AW'(i)) rdata[CFG_W-1:0] = cfg_q[i];
    end
    if (addr == LOCK_A) rdata[NPINS-1:0] = lock_q;
    if (addr == STAT_A) rdata[NPINS-1:0] = status_i;
    if (addr == LVL_A)  rdata[NPINS-1:0] = level_i;
  end

endmodule

// File: rtl/gpio_events.sv
module gpio_events
  import gpio_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] level_i,
  input  logic [NPINS-1:0] rise_sel,
  input  logic [NPINS-1:0] irq_en,
  input  logic [NPINS-1:0] smi_en,
  input  logic [NPINS-1:0] wake_en,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] status_o,
  output logic             irq_o,
  output logic             smi_o,
  output logic             wake_o
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] stat_q;
  logic [NPINS-1:0] hit;

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      hit[i] = edge_hit(rise_sel[i], prev_q[i], level_i[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= level_i;
      stat_q <= (stat_q & ~clr_i) | hit;
    end
  end

  assign status_o = stat_q;
  assign irq_o    = |(stat_q & irq_en);
  assign smi_o    = |(stat_q & smi_en);
  assign wake_o   = |(stat_q & wake_en);

  genvar gi;
  generate
    for (gi = 0; gi < NPINS; gi++) begin : g_chk
      // R8
      stat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[gi]) |-> $past(hit[gi]));
      // R9
      stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[gi] && !hit[gi]) |=> !stat_q[gi]);
    end
  endgenerate

  // R10
  route_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |-> (!irq_o && !smi_o && !wake_o));

endmodule

// File: rtl/lockgpio_bank.sv
module lockgpio_bank
  import gpio_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int DB_LEN = 16,
  localparam int DW    = (NPINS > CFG_W) ? NPINS : CFG_W,
  localparam int AW    = $clog2(NPINS + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_pu,
  output logic             irq_o,
  output logic             smi_o,
  output logic             wake_o
);
  pin_cfg_t         cfg [NPINS];
  logic [NPINS-1:0] lock;
  logic [NPINS-1:0] clr;
  logic [NPINS-1:0] status;
  logic [NPINS-1:0] level;
  logic [NPINS-1:0] rise_v, irq_v, smi_v, wake_v;

  gpio_regs #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .status_i(status),
    .level_i(level), .cfg_q(cfg), .lock_q(lock), .clr_o(clr)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NPINS; gi++) begin : g_pin
      gpio_debounce #(.DB_LEN(DB_LEN)) u_db (
        .clk(clk), .rst_n(rst_n), .raw_in(pin_in[gi]), .level_o(level[gi])
      );

      assign pin_out[gi] = cfg[gi].dout;
      assign pin_oe[gi]  = drive_oe(cfg[gi].drive, cfg[gi].dout);
      assign pin_pu[gi]  = cfg[gi].pull_en;
      assign rise_v[gi]  = cfg[gi].rise_sel;
      assign irq_v[gi]   = cfg[gi].irq_en;
      assign smi_v[gi]   = cfg[gi].smi_en;
      assign wake_v[gi]  = cfg[gi].wake_en;

      // R2
      od_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg[gi].drive == DRV_OPEN && pin_oe[gi] && pin_out[gi]));
    end
  endgenerate

  gpio_events #(.NPINS(NPINS)) u_ev (
    .clk(clk), .rst_n(rst_n), .level_i(level), .rise_sel(rise_v),
    .irq_en(irq_v), .smi_en(smi_v), .wake_en(wake_v), .clr_i(clr),
    .status_o(status), .irq_o(irq_o), .smi_o(smi_o), .wake_o(wake_o)
  );

endmodule

// File: tb/lockgpio_bank_test.sv
module lockgpio_bank_test;
  localparam int NP = 8;
  localparam logic [3:0] A_LOCK = 4'd8, A_STAT = 4'd9, A_LVL = 4'd10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pin_pu;
  logic          irq_o, smi_o, wake_o;
  int            n_run = 0, n_fail = 0;
  logic [7:0]    rv;

  always #2 clk = ~clk;

  lockgpio_bank uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
    .irq_o(irq_o), .smi_o(smi_o), .wake_o(wake_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 oe", pin_oe, 0);
    chk("R1 pu", pin_pu, 0);
    chk("R1 events", {irq_o, smi_o, wake_o}, 0);
    rd(A_LOCK, rv); chk("R1 lock", rv, 0);
    rd(A_STAT, rv); chk("R1 status", rv, 0);
    rd(4'd3, rv);   chk("R1 cfg3", rv, 0);
  endtask

  task automatic t_drive;
    wr(4'd0, 8'h09); #1;
    chk("R2 push-pull oe", pin_oe[0], 1);
    chk("R2 push-pull out", pin_out[0], 1);
    wr(4'd1, 8'h0A); #1;
    chk("R2 open-drain high oe", pin_oe[1], 0);
    wr(4'd1, 8'h02); #1;
    chk("R2 open-drain low oe", pin_oe[1], 1);
    chk("R2 open-drain low out", pin_out[1], 0);
    wr(4'd2, 8'h0B); #1;
    chk("R2 code 11 oe", pin_oe[2], 0);
    wr(4'd3, 8'h08); #1;
    chk("R2 off oe", pin_oe[3], 0);
    chk("R2 off out", pin_out[3], 1);
  endtask

  task automatic t_pull;
    wr(4'd4, 8'h04); #1;
    chk("R3 pull-up", pin_pu, 8'h10);
    rd(4'd4, rv); chk("R4 readback cfg4", rv, 8'h04);
    rd(4'd1, rv); chk("R4 readback cfg1", rv, 8'h02);
  endtask

  task automatic t_debounce;
    @(negedge clk); pin_in[5] = 1'b1;
    cyc(15); pin_in[5] = 1'b0;
    cyc(30);
    rd(A_LVL, rv); chk("R7 15-clock pulse rejected", rv[5], 0);
    @(negedge clk); pin_in[5] = 1'b1;
    cyc(16); pin_in[5] = 1'b0;
    cyc(3);
    rd(A_LVL, rv); chk("R7 16-clock pulse accepted", rv[5], 1);
    cyc(30);
    rd(A_LVL, rv); chk("R7 return low accepted", rv[5], 0);
    @(negedge clk); pin_in[5] = 1'b1;
    cyc(10);
    rd(A_LVL, rv); chk("R7 not yet settled", rv[5], 0);
    cyc(15);
    rd(A_LVL, rv); chk("R7 settled high", rv[5], 1);
  endtask

  task automatic t_events;
    wr(A_STAT, 8'hFF);
    wr(4'd6, 8'h30);
    @(negedge clk); pin_in[6] = 1'b1;
    cyc(25); #1;
    chk("R10 irq routed", irq_o, 1);
    chk("R10 smi/wake unrouted", {smi_o, wake_o}, 0);
    rd(A_STAT, rv); chk("R8 rising sets pending", rv[6], 1);
    wr(A_STAT, 8'h00);
    rd(A_STAT, rv); chk("R9 zero write keeps", rv[6], 1);
    wr(A_STAT, 8'h40); #1;
    rd(A_STAT, rv); chk("R9 one write clears", rv[6], 0);
    chk("R10 irq drops", irq_o, 0);
    wr(4'd7, 8'hC0);
    @(negedge clk); pin_in[7] = 1'b1;
    cyc(25);
    rd(A_STAT, rv); chk("R8 wrong edge ignored", rv[7], 0);
    @(negedge clk); pin_in[7] = 1'b0;
    cyc(25); #1;
    rd(A_STAT, rv); chk("R8 falling sets pending", rv[7], 1);
    chk("R10 smi+wake routed", {irq_o, smi_o, wake_o}, 3'b011);
    wr(A_STAT, 8'h80); #1;
    chk("R10 lines idle", {irq_o, smi_o, wake_o}, 0);
  endtask

  task automatic t_lock;
    wr(A_LOCK, 8'h01);
    rd(A_LOCK, rv); chk("R5 lock set", rv, 8'h01);
    wr(4'd0, 8'h00); #1;
    chk("R6 locked oe kept", pin_oe[0], 1);
    rd(4'd0, rv); chk("R6 locked cfg kept", rv, 8'h09);
    wr(4'd1, 8'h01); #1;
    chk("R6 unlocked pin writable", pin_oe[1], 1);
    wr(A_LOCK, 8'h00);
    rd(A_LOCK, rv); chk("R5 zero write no clear", rv, 8'h01);
    @(negedge clk); rst_n = 1'b0;
    cyc(2); rst_n = 1'b1;
    rd(A_LOCK, rv); chk("R5 reset clears lock", rv, 0);
  endtask

  initial begin
    cyc(5);
    rst_n = 1'b1;
    t_reset;
    t_drive;
    t_pull;
    t_debounce;
    t_events;
    t_lock;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule